// File: doc/BRIEF.md
# Partial-Word Load/Store Merge Unit

This unit executes the four unaligned word instructions of a 32-bit load/store core: load-left, load-right, store-left and store-right. The core hands it an operation, a byte address and the current value of the target register. The unit only ever reaches memory through an aligned word port, so every access uses the address with its two low bits cleared. Those two bits choose which byte lanes move.

A load reads the aligned word once and merges a shifted copy of it into the old register value. The result is offered to the register file for one cycle. A store has no byte enables to rely on, so it reads the aligned word, merges the shifted register value into it, and writes the full word back. A small sequencer performs one operation at a time and uses valid/ready handshakes toward the core and toward memory.

Byte lanes are numbered from lane 0 (bits 7:0) to lane 3 (bits 31:24). The offset k is address bits 1:0.

Top module: `pwm_unit`

## Requirements
- R1: Every memory request carries the request address with bits 1:0 forced to zero. Address bits 1:0 form the offset k that selects the merge pattern.
- R2: Load-left (op code 2'b00) returns (mem << (24-8k)). It keeps the old register bits under masks 0x00FFFFFF, 0x0000FFFF, 0x000000FF and 0x00000000 for k = 0, 1, 2, 3.
- R3: Load-right (op code 2'b01) returns (mem >> 8k). It keeps the old register bits under masks 0x00000000, 0xFF000000, 0xFFFF0000 and 0xFFFFFF00 for k = 0, 1, 2, 3.
- R4: Store-left (op code 2'b10) writes (reg >> (24-8k)) ORed with the old memory bits under masks 0xFFFFFF00, 0xFFFF0000, 0xFF000000 and 0x00000000 for k = 0..3.
- R5: Store-right (op code 2'b11) writes (reg << 8k) ORed with the old memory bits under masks 0x00000000, 0x000000FF, 0x0000FFFF and 0x00FFFFFF for k = 0..3.
- R6: A store issues exactly one read of the aligned word and then exactly one write to the same word. A load issues one read and no write.
- R7: While a memory request is valid and not yet accepted, its valid, write flag and address hold steady.
- R8: A load raises rf_we with the merged value on rf_wdata and the register index on rf_idx during its done cycle. A load whose register index is 0 leaves rf_we low.
- R9: done is high for exactly one cycle per operation, and req_ready returns high in the next cycle. req_ready is high only while no operation is in flight. A store never raises rf_we.
- R10: After a synchronous reset: req_ready is 1, and mem_req_valid, rf_we and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit idle, accepts an operation |
| req_op | input | 2 | Bit 1: store, bit 0: right variant |
| req_addr | input | 32 | Effective byte address |
| req_rt_idx | input | 5 | Target/source register index |
| req_rt_val | input | 32 | Current register value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned address |
| mem_req_wdata | output | 32 | Merged word to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 5 | Register index to write |
| rf_wdata | output | 32 | Merged register value |
| done | output | 1 | Operation complete pulse |

## Verification
The assertions assume that memory returns exactly one read response for each accepted read and no response at any other time. They also assume that req_valid is offered only while req_ready is high. The bench memory model produces one response per accepted read, one cycle after acceptance. It drops ready on a repeating pattern, so requests have to wait at times. The driver task waits for req_ready before presenting each operation and holds req_valid for exactly one cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // bit 1: store, bit 0: right-hand variant
  typedef enum logic [1:0] {
    OP_LOAD_LEFT   = 2'b00,
    OP_LOAD_RIGHT  = 2'b01,
    OP_STORE_LEFT  = 2'b10,
    OP_STORE_RIGHT = 2'b11
  } pwm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_DONE
  } pwm_state_e;
endpackage

// File: rtl/pwm_load_merge.sv
module pwm_load_merge #(
  parameter int XLEN = 32
) (
  input  logic                        right,
  input  logic [$clog2(XLEN/8)-1:0]   off,
  input  logic [XLEN-1:0]             mem_word,
  input  logic [XLEN-1:0]             reg_word,
  output logic [XLEN-1:0]             merged
);
  localparam int LANES = XLEN / 8;
  localparam int SH_W  = $clog2(XLEN) + 1;
  localparam logic [XLEN-1:0] ONES = '1;

  logic [SH_W-1:0] sh;
  logic [SH_W-1:0] sh_inv;

  always_comb begin
    if (right) sh = SH_W'(8 * int'(off));
    else       sh = SH_W'(8 * (LANES - 1 - int'(off)));
    sh_inv = SH_W'(XLEN) - sh;
    if (right)
      merged = (mem_word >> sh) | (reg_word & ~(ONES >> sh));
    else
      merged = (mem_word << sh) | (reg_word & (ONES >> sh_inv));
  end
endmodule

// File: rtl/pwm_store_merge.sv
module pwm_store_merge #(
  parameter int XLEN = 32
) (
  input  logic                        right,
  input  logic [$clog2(XLEN/8)-1:0]   off,
  input  logic [XLEN-1:0]             mem_word,
  input  logic [XLEN-1:0]             reg_word,
  output logic [XLEN-1:0]             merged
);
  localparam int LANES = XLEN / 8;
  localparam int SH_W  = $clog2(XLEN) + 1;
  localparam logic [XLEN-1:0] ONES = '1;

  logic [SH_W-1:0] sh;

  always_comb begin
    if (right) sh = SH_W'(8 * int'(off));
    else       sh = SH_W'(8 * (LANES - 1 - int'(off)));
    if (right)
      merged = (reg_word << sh) | (mem_word & ~(ONES << sh));
    else
      merged = (reg_word >> sh) | (mem_word & ~(ONES >> sh));
  end
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit #(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [XLEN-1:0]      req_addr,
  input  logic [REG_IDX_W-1:0] req_rt_idx,
  input  logic [XLEN-1:0]      req_rt_val,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [XLEN-1:0]      mem_req_addr,
  output logic [XLEN-1:0]      mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [XLEN-1:0]      mem_rsp_rdata,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_idx,
  output logic [XLEN-1:0]      rf_wdata,
  output logic                 done
);
  import pwm_pkg::*;

  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);

  pwm_state_e             st;
  pwm_op_e                op_q;
  logic [XLEN-1:0]        waddr_q;
  logic [OFF_W-1:0]       off_q;
  logic [REG_IDX_W-1:0]   idx_q;
  logic [XLEN-1:0]        rval_q;
  logic [XLEN-1:0]        wdata_q;
  logic                   rf_we_q;
  logic [XLEN-1:0]        rf_wdata_q;
  logic [XLEN-1:0]        ld_merged;
  logic [XLEN-1:0]        st_merged;
  logic                   is_store;

  assign is_store = op_q[1];

  pwm_load_merge #(.XLEN(XLEN)) u_ld (
    .right    (op_q[0]),
    .off      (off_q),
    .mem_word (mem_rsp_rdata),
    .reg_word (rval_q),
    .merged   (ld_merged)
  );

  pwm_store_merge #(.XLEN(XLEN)) u_st (
    .right    (op_q[0]),
    .off      (off_q),
    .mem_word (mem_rsp_rdata),
    .reg_word (rval_q),
    .merged   (st_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_q       <= OP_LOAD_LEFT;
      waddr_q    <= '0;
      off_q      <= '0;
      idx_q      <= '0;
      rval_q     <= '0;
      wdata_q    <= '0;
      rf_we_q    <= 1'b0;
      rf_wdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          rf_we_q <= 1'b0;
          if (req_valid) begin
            op_q    <= pwm_op_e'(req_op);
            waddr_q <= {req_addr[XLEN-1:OFF_W], {OFF_W{1'b0}}};
            off_q   <= req_addr[OFF_W-1:0];
            idx_q   <= req_rt_idx;
            rval_q  <= req_rt_val;
            st      <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (mem_req_ready) st <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            if (is_store) begin
              wdata_q <= st_merged;
              st      <= ST_WR_REQ;
            end else begin
              rf_wdata_q <= ld_merged;
              rf_we_q    <= (idx_q != '0);
              st         <= ST_DONE;
            end
          end
        end
        ST_WR_REQ: if (mem_req_ready) st <= ST_DONE;
        ST_DONE: begin
          rf_we_q <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_RD_REQ) || (st == ST_WR_REQ);
  assign mem_req_we    = (st == ST_WR_REQ);
  assign mem_req_addr  = waddr_q;
  assign mem_req_wdata = wdata_q;
  assign done          = (st == ST_DONE);
  assign rf_we         = rf_we_q;
  assign rf_idx        = idx_q;
  assign rf_wdata      = rf_wdata_q;
endmodule

// File: rtl/pwm_unit_checker.sv
module pwm_unit_checker #(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_ready,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic                 mem_req_we,
  input logic [XLEN-1:0]      mem_req_addr,
  input logic                 rf_we,
  input logic [REG_IDX_W-1:0] rf_idx,
  input logic                 done
);
  p_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)));

  p_write_follows_read_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_we) |-> $past(!mem_req_we && !req_ready));

  p_no_zero_write_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_idx != '0));

  p_we_in_done_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req_valid && !done));
endmodule

bind pwm_unit pwm_unit_checker #(.XLEN(XLEN), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .rf_we         (rf_we),
  .rf_idx        (rf_idx),
  .done          (done)
);

// File: tb/pwm_unit_bench.sv
module pwm_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 16;

  typedef struct {
    logic        is_load;
    logic [4:0]  idx;
    logic [31:0] val;
    logic [3:0]  widx;
    int          wr_at_issue;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_rt_idx = '0;
  logic [31:0] req_rt_val = '0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        rf_we, done;
  logic [4:0]  rf_idx;
  logic [31:0] rf_wdata;

  logic [31:0] mem [WORDS];
  int          wr_count = 0;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  item_t       sb_q[$];
  bit          expect_idle = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_unit u_pwm_unit (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_rt_idx(req_rt_idx), .req_rt_val(req_rt_val),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata), .done(done)
  );

  // memory model: ready drops one cycle in three, read data one cycle after acceptance
  assign mem_req_ready = (cyc % 3) != 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_we;
      mem_rsp_rdata <= mem[mem_req_addr[5:2]];
      if (mem_req_valid && mem_req_ready && mem_req_we) begin
        mem[mem_req_addr[5:2]] <= mem_req_wdata;
        wr_count <= wr_count + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent byte-lane reference; lane j = bits 8j+7:8j
  function automatic logic [31:0] ref_merge(input logic [1:0] op, input int k,
                                            input logic [31:0] m, input logic [31:0] r);
    logic [31:0] res;
    for (int j = 0; j < 4; j++) begin
      logic [7:0] b;
      case (op)
        2'b00: b = (j >= 3 - k) ? m[8*(j-(3-k)) +: 8] : r[8*j +: 8];
        2'b01: b = (j <= 3 - k) ? m[8*(j+k) +: 8]     : r[8*j +: 8];
        2'b10: b = (j <= k)     ? r[8*(j+3-k) +: 8]   : m[8*j +: 8];
        default: b = (j >= k)   ? r[8*(j-k) +: 8]     : m[8*j +: 8];
      endcase
      res[8*j +: 8] = b;
    end
    return res;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [31:0] addr,
                       input logic [4:0] idx, input logic [31:0] rv);
    item_t it;
    while (!req_ready) @(negedge clk);
    it.is_load     = !op[1];
    it.idx         = idx;
    it.widx        = addr[5:2];
    it.val         = ref_merge(op, int'(addr[1:0]), mem[addr[5:2]], rv);
    it.wr_at_issue = wr_count;
    sb_q.push_back(it);
    req_valid  = 1'b1;
    req_op     = op;
    req_addr   = addr;
    req_rt_idx = idx;
    req_rt_val = rv;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (expect_idle) begin
        check(req_ready && !done, "R9 done pulse/idle", {30'd0, req_ready, done}, 32'h2);
        expect_idle = 0;
      end
      if (done) begin
        item_t it;
        expect_idle = 1;
        if (sb_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", 32'd1, 32'd0);
        end else begin
          it = sb_q.pop_front();
          if (it.is_load) begin
            check(wr_count == it.wr_at_issue, "R6 load wrote memory",
                  32'(wr_count - it.wr_at_issue), 32'd0);
            if (it.idx == 5'd0) begin
              check(!rf_we, "R8 r0 write suppressed", {31'd0, rf_we}, 32'd0);
            end else begin
              check(rf_we && rf_idx == it.idx, "R8 rf_we/idx", {26'd0, rf_we, rf_idx},
                    {26'd0, 1'b1, it.idx});
              check(rf_wdata == it.val, "R2/R3 load merge", rf_wdata, it.val);
            end
          end else begin
            check(!rf_we, "R9 store rf_we", {31'd0, rf_we}, 32'd0);
            check(wr_count == it.wr_at_issue + 1, "R6 one write per store",
                  32'(wr_count - it.wr_at_issue), 32'd1);
            check(mem[it.widx] == it.val, "R1/R4/R5 store word", mem[it.widx], it.val);
          end
        end
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R9 watchdog expired actual=hung expected=complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 32'h11223344 ^ (32'h01010101 * i) ^ (i << 28);
    repeat (3) @(negedge clk);
    // R10 reset state while reset is held
    check(req_ready && !mem_req_valid && !rf_we && !done, "R10 reset state",
          {28'd0, req_ready, mem_req_valid, rf_we, done}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    // all four operations at all four offsets (R1..R5)
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 4; k++) begin
        issue(2'(op), 32'h8000_0000 + 32'((op * 4 + k) % WORDS) * 4 + 32'(k),
              5'(1 + op * 4 + k), 32'hA1B2C3D4 ^ (32'h0F0F0F0F * op) ^ 32'(k << 8));
      end
    end
    // R8: load into register zero is suppressed
    issue(2'b00, 32'h0000_0011, 5'd0, 32'hDEADBEEF);
    issue(2'b01, 32'h0000_0016, 5'd0, 32'h12345678);
    // store then load back the same word (R4, R3)
    issue(2'b10, 32'h0000_0022, 5'd7, 32'hCAFEF00D);
    issue(2'b11, 32'h0000_0021, 5'd8, 32'h5A5A5A5A);
    issue(2'b01, 32'h0000_0023, 5'd9, 32'hFFFFFFFF);
    issue(2'b00, 32'h0000_0020, 5'd31, 32'h00000000);
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule